// File: doc/BRIEF.md
# Seven-Level Multicarrier Unipolar PWM Modulator

This block turns a stream of signed reference samples into gating decisions for a seven-level single-phase inverter. It takes the absolute value of each sample and compares it against three triangular carriers. All three carriers share one frequency and one amplitude, and all of them sit above zero. Each carrier owns one on/off decision. The number of carriers currently exceeded gives the level magnitude (0 to 3), and the sign of the sample gives the polarity. Mapping those levels onto power switches is left to logic downstream.

The three carriers come from one shared up/down counter that advances only while a step enable is high, so the carrier frequency is set by how often step pulses arrive. A half-period input sets the carrier amplitude. A strategy select chooses how the carriers are stacked. In disposition mode they sit in adjacent bands and move in phase. In alternate mode they keep adjacent bands, but the middle carrier runs inverted. In overlap mode they move in phase and each one sits half an amplitude above the one below it. A new strategy takes effect only when the counter reaches zero. This keeps each carrier period internally consistent. With a step every sample and a half-period chosen for the target ratio, the nominal setup is 40 carrier periods per reference period.

Top module: `mlpwm_top`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `gate_on`, `level_mag`, `polarity` and `out_vld` to 0, returns the counter to 0 counting upward, and loads the active strategy from `strat_sel`.
- R2: `out_vld` is high exactly one cycle after a cycle with `ref_vld` high. `gate_on`, `level_mag` and `polarity` change only on those result cycles, and hold their values otherwise.
- R3: For each carrier k, the result sets `gate_on[k]` to 1 when the magnitude of the sample exceeds carrier k, and to 0 when the magnitude is below it. `ref_smp` is two's complement, and its MSB is the sign. Carrier values are taken from the cycle in which the sample is presented.
- R4: When the sample magnitude equals carrier k, `gate_on[k]` keeps its previous value.
- R5: `level_mag` is the number of ones in `gate_on`. `polarity` is 1 (negative) only when the sample is negative and `level_mag` is nonzero, so a zero level is always reported as positive.
- R6: The counter moves one step per cycle with `step_en` high. It follows the sequence 0, 1, …, H, H-1, …, 1, 0, 1, …, where H is `half_period`, and it holds while `step_en` is low.
- R7: In disposition mode (`strat_sel` 0, and also 3), carrier k equals the counter plus k·H.
- R8: In alternate mode (`strat_sel` 1), carrier 1 equals (H minus the counter) plus H. Carriers 0 and 2 equal the counter plus k·H.
- R9: In overlap mode (`strat_sel` 2), carrier k equals the counter plus k·floor(H/2).
- R10: The active strategy is reloaded from `strat_sel` only on a step that brings the counter to 0, or during reset. A select change at any other time has no effect on the carriers until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the carrier counter by one step |
| half_period | input | CNT_W | Carrier amplitude H, i.e. steps per half carrier period |
| strat_sel | input | 2 | Requested carrier strategy: 0 disposition, 1 alternate, 2 overlap, 3 disposition |
| ref_vld | input | 1 | Reference sample present this cycle |
| ref_smp | input | SAMPLE_W | Two's complement reference sample |
| gate_on | output | 3 | Per-carrier on/off decision |
| level_mag | output | 2 | Level magnitude 0..3 |
| polarity | output | 1 | 1 when the level is negative |
| out_vld | output | 1 | Result strobe, one cycle after `ref_vld` |

## Verification
The counter-bound property assumes that `half_period` stays at or above 2 and is never changed while the block is out of reset. The bench therefore fixes H at 8 for the whole run. The equality-hold and above-carrier properties need no assumption on the sample value. The bench feeds magnitudes that run past the top carrier, the full negative range and zero, and it also places samples exactly on a carrier value taken from its own model of the counter. The strategy select is changed in the middle of a carrier period, so the delayed takeover at the counter's minimum is exercised and not just a change at a boundary.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int N_CARRIERS = 3;
    localparam int LVL_W      = $clog2(N_CARRIERS + 1);

    typedef enum logic [1:0] {
        STRAT_DISP = 2'd0,
        STRAT_ALT  = 2'd1,
        STRAT_OVLP = 2'd2
    } strat_e;

    typedef struct packed {
        logic [N_CARRIERS-1:0] gate;
        logic [LVL_W-1:0]      level;
        logic                  neg;
    } mlpwm_res_t;

    function automatic strat_e decode_strat(input logic [1:0] sel);
        case (sel)
            2'd1:    return STRAT_ALT;
            2'd2:    return STRAT_OVLP;
            default: return STRAT_DISP;
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] count_on(input logic [N_CARRIERS-1:0] g);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int i = 0; i < N_CARRIERS; i++) begin
            n = n + LVL_W'(g[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/mlpwm_carrier_gen.sv
module mlpwm_carrier_gen
    import mlpwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int N_CAR = N_CARRIERS,
    parameter int CAR_W = CNT_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   step_en,
    input  logic [CNT_W-1:0]       half_period,
    input  logic [1:0]             strat_sel,
    output logic [N_CAR*CAR_W-1:0] car_flat,
    output logic [CNT_W-1:0]       cnt_o,
    output strat_e                 strat_o
);

    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             up_q, up_n;
    strat_e           strat_q;

    always_comb begin
        cnt_n = cnt_q;
        up_n  = up_q;
        if (up_q) begin
            if (cnt_q >= half_period) begin
                up_n  = 1'b0;
                cnt_n = (cnt_q == '0) ? cnt_q : cnt_q - CNT_W'(1);
            end else begin
                cnt_n = cnt_q + CNT_W'(1);
            end
        end else begin
            if (cnt_q == '0) begin
                up_n  = 1'b1;
                cnt_n = CNT_W'(1);
            end else begin
                cnt_n = cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            up_q    <= 1'b1;
            strat_q <= decode_strat(strat_sel);
        end else if (step_en) begin
            cnt_q <= cnt_n;
            up_q  <= up_n;
            if (cnt_n == '0) begin
                strat_q <= decode_strat(strat_sel);
            end
        end
    end

    for (genvar k = 0; k < N_CAR; k++) begin : g_car
        logic [CNT_W-1:0] base;
        logic [CAR_W-1:0] offs;
        always_comb begin
            case (strat_q)
                STRAT_ALT: begin
                    base = ((k % 2) == 1) ? (half_period - cnt_q) : cnt_q;
                    offs = CAR_W'(k) * CAR_W'(half_period);
                end
                STRAT_OVLP: begin
                    base = cnt_q;
                    offs = CAR_W'(k) * CAR_W'(half_period >> 1);
                end
                default: begin
                    base = cnt_q;
                    offs = CAR_W'(k) * CAR_W'(half_period);
                end
            endcase
        end
        assign car_flat[k*CAR_W +: CAR_W] = CAR_W'(base) + offs;
    end

    assign cnt_o   = cnt_q;
    assign strat_o = strat_q;

endmodule

// File: rtl/mlpwm_slice.sv
module mlpwm_slice #(
    parameter int CMP_W = 13
) (
    input  logic [CMP_W-1:0] mag,
    input  logic [CMP_W-1:0] car,
    input  logic             prev_on,
    output logic             next_on
);

    always_comb begin
        if (mag > car) begin
            next_on = 1'b1;
        end else if (mag < car) begin
            next_on = 1'b0;
        end else begin
            next_on = prev_on;
        end
    end

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
    import mlpwm_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int CNT_W    = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  step_en,
    input  logic [CNT_W-1:0]      half_period,
    input  logic [1:0]            strat_sel,
    input  logic                  ref_vld,
    input  logic [SAMPLE_W-1:0]   ref_smp,
    output logic [N_CARRIERS-1:0] gate_on,
    output logic [LVL_W-1:0]      level_mag,
    output logic                  polarity,
    output logic                  out_vld
);

    localparam int N_CAR = N_CARRIERS;
    localparam int CAR_W = CNT_W + 2;
    localparam int CMP_W = ((SAMPLE_W > CAR_W) ? SAMPLE_W : CAR_W) + 1;

    logic [N_CAR*CAR_W-1:0] car_flat;
    logic [N_CAR*CMP_W-1:0] car_x;
    logic [CNT_W-1:0]       cnt_w;
    strat_e                 strat_w;
    logic                   neg;
    logic [SAMPLE_W-1:0]    mag;
    logic [CMP_W-1:0]       mag_x;
    logic [N_CAR-1:0]       gate_n;
    mlpwm_res_t             res_n, res_q;
    logic                   vld_q;

    mlpwm_carrier_gen #(
        .CNT_W (CNT_W),
        .N_CAR (N_CAR),
        .CAR_W (CAR_W)
    ) u_car (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .half_period (half_period),
        .strat_sel   (strat_sel),
        .car_flat    (car_flat),
        .cnt_o       (cnt_w),
        .strat_o     (strat_w)
    );

    assign neg   = ref_smp[SAMPLE_W-1];
    assign mag   = neg ? (~ref_smp + SAMPLE_W'(1)) : ref_smp;
    assign mag_x = CMP_W'(mag);

    for (genvar k = 0; k < N_CAR; k++) begin : g_cmp
        assign car_x[k*CMP_W +: CMP_W] = CMP_W'(car_flat[k*CAR_W +: CAR_W]);
        mlpwm_slice #(.CMP_W(CMP_W)) u_slice (
            .mag     (mag_x),
            .car     (car_x[k*CMP_W +: CMP_W]),
            .prev_on (res_q.gate[k]),
            .next_on (gate_n[k])
        );
    end

    always_comb begin
        res_n.gate  = gate_n;
        res_n.level = count_on(gate_n);
        res_n.neg   = neg && (res_n.level != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= ref_vld;
            if (ref_vld) begin
                res_q <= res_n;
            end
        end
    end

    assign gate_on   = res_q.gate;
    assign level_mag = res_q.level;
    assign polarity  = res_q.neg;
    assign out_vld   = vld_q;

endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk
    import mlpwm_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int CMP_W = 13
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        ref_vld,
    input logic [CNT_W-1:0]            half_period,
    input logic [N_CARRIERS-1:0]       gate_on,
    input logic [LVL_W-1:0]            level_mag,
    input logic                        polarity,
    input logic                        out_vld,
    input logic [CNT_W-1:0]            cnt,
    input strat_e                      strat,
    input logic [CMP_W-1:0]            mag_x,
    input logic [N_CARRIERS*CMP_W-1:0] car_x
);

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ref_vld |=> out_vld);

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        !ref_vld |=> ($stable(gate_on) && $stable(level_mag) && $stable(polarity)));

    p_zero_positive_r5: assert property (@(posedge clk) disable iff (rst)
        (level_mag == '0) |-> !polarity);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= half_period);

    p_strat_at_min_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(strat) |-> (cnt == '0));

    for (genvar k = 0; k < N_CARRIERS; k++) begin : g_k
        p_above_on_r3: assert property (@(posedge clk) disable iff (rst)
            (ref_vld && (mag_x > car_x[k*CMP_W +: CMP_W])) |=> gate_on[k]);

        p_below_off_r3: assert property (@(posedge clk) disable iff (rst)
            (ref_vld && (mag_x < car_x[k*CMP_W +: CMP_W])) |=> !gate_on[k]);

        p_equal_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (ref_vld && (mag_x == car_x[k*CMP_W +: CMP_W])) |=> $stable(gate_on[k]));
    end

endmodule

bind mlpwm_top mlpwm_chk #(
    .CNT_W (CNT_W),
    .CMP_W (CMP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_vld     (ref_vld),
    .half_period (half_period),
    .gate_on     (gate_on),
    .level_mag   (level_mag),
    .polarity    (polarity),
    .out_vld     (out_vld),
    .cnt         (cnt_w),
    .strat       (strat_w),
    .mag_x       (mag_x),
    .car_x       (car_x)
);

// File: tb/test_mlpwm_top.sv
`timescale 1ns/1ps
module test_mlpwm_top;

    localparam int SW = 12;
    localparam int CW = 10;
    localparam int HP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          step_en;
    logic [CW-1:0] half_period;
    logic [1:0]    strat_sel;
    logic          ref_vld;
    logic [SW-1:0] ref_smp;
    logic [2:0]    gate_on;
    logic [1:0]    level_mag;
    logic          polarity;
    logic          out_vld;

    always #2.5 clk = ~clk;

    mlpwm_top #(.SAMPLE_W(SW), .CNT_W(CW)) i_mlpwm_top (
        .clk         (clk),
        .rst         (rst),
        .step_en     (step_en),
        .half_period (half_period),
        .strat_sel   (strat_sel),
        .ref_vld     (ref_vld),
        .ref_smp     (ref_smp),
        .gate_on     (gate_on),
        .level_mag   (level_mag),
        .polarity    (polarity),
        .out_vld     (out_vld)
    );

    typedef struct {
        logic [2:0] gate;
        logic [1:0] level;
        logic       neg;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_vec = 0;
    int         n_bad = 0;
    logic [2:0] last_gate = '0;
    logic [1:0] last_level = '0;
    logic       last_neg = 1'b0;

    // bench model of counter, strategy and held gate state
    int         m_cnt;
    bit         m_up;
    int         m_strat;
    logic [2:0] m_gate;

    function automatic int dec(input logic [1:0] s);
        return (s == 2'd1) ? 1 : (s == 2'd2) ? 2 : 0;
    endfunction

    function automatic int bcar(input int k);
        if (m_strat == 1) return (((k % 2) == 1) ? (HP - m_cnt) : m_cnt) + k * HP;
        if (m_strat == 2) return m_cnt + k * (HP / 2);
        return m_cnt + k * HP;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input int smp, input bit v, input bit step, input string tag);
        exp_t e;
        int   mag;
        int   c;
        @(negedge clk);
        ref_vld = v;
        ref_smp = SW'(smp);
        step_en = step;
        if (v) begin
            mag = (smp < 0) ? -smp : smp;
            for (int k = 0; k < 3; k++) begin
                c = bcar(k);
                if (mag > c) m_gate[k] = 1'b1;
                else if (mag < c) m_gate[k] = 1'b0;
            end
            e.gate  = m_gate;
            e.level = 2'(m_gate[0] + m_gate[1] + m_gate[2]);
            e.neg   = (smp < 0) && (e.level != 0);
            e.tag   = tag;
            sb.push_back(e);
        end
        if (step) begin
            if (m_up) begin
                if (m_cnt >= HP) begin
                    m_up = 1'b0;
                    m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                end else begin
                    m_cnt++;
                end
            end else if (m_cnt == 0) begin
                m_up = 1'b1;
                m_cnt = 1;
            end else begin
                m_cnt--;
            end
            if (m_cnt == 0) m_strat = dec(strat_sel);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        drive(0, 0, 0, "idle");
        @(negedge clk);
        strat_sel = sel;
        rst = 1'b1;
        ref_vld = 1'b0;
        step_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while in reset
        check("R1 gate", int'(gate_on), 0);
        check("R1 level", int'(level_mag), 0);
        check("R1 polarity", int'(polarity), 0);
        check("R1 out_vld", int'(out_vld), 0);
        sb.delete();
        m_cnt = 0; m_up = 1'b1; m_strat = dec(sel); m_gate = '0;
        last_gate = '0; last_level = '0; last_neg = 1'b0;
        rst = 1'b0;
    endtask

    task automatic sweep(input int n, input int seed, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(((i * 13 + seed) % 61) - 30, 1'b1, (i % 4) != 3, tag);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (out_vld) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected out_vld", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " gate"}, int'(gate_on), int'(e.gate));
                    check("R5 level", int'(level_mag), int'(e.level));
                    check("R5 polarity", int'(polarity), int'(e.neg));
                    last_gate = gate_on; last_level = level_mag; last_neg = polarity;
                end
            end else if (sb.size() == 0) begin
                check("R2 hold gate", int'(gate_on), int'(last_gate));
                check("R2 hold level", int'(level_mag), int'(last_level));
                check("R2 hold polarity", int'(polarity), int'(last_neg));
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        step_en = 1'b0;
        ref_vld = 1'b0;
        ref_smp = '0;
        strat_sel = 2'd0;
        half_period = CW'(HP);
        do_reset(2'd0);

        sweep(60, 0, "R3 R6 R7");

        // R4: sample equal to carrier 1 holds its state
        drive(2000, 1'b1, 1'b0, "R4 setup");
        drive(bcar(1), 1'b1, 1'b1, "R4 hold on");
        drive(0, 1'b1, 1'b0, "R4 setup");
        drive(bcar(1), 1'b1, 1'b1, "R4 hold off");
        drive(bcar(0), 1'b1, 1'b0, "R4 carrier0");

        // R2: idle cycles with stepping, outputs must hold
        for (int i = 0; i < 6; i++) drive(25, 1'b0, 1'b1, "R2 idle");

        strat_sel = 2'd1;
        sweep(40, 5, "R8 R10");
        strat_sel = 2'd2;
        sweep(40, 11, "R9 R10");
        strat_sel = 2'd3;
        sweep(40, 17, "R7 R10");

        drive(-2048, 1'b1, 1'b1, "R3 R5 full negative");
        drive(2047, 1'b1, 1'b1, "R3 R5 full positive");
        drive(0, 1'b1, 1'b1, "R5 zero");
        drive(-1, 1'b1, 1'b1, "R5 minus one");
        drive(-24, 1'b1, 1'b1, "R5 top");
        drive(-30, 1'b1, 1'b0, "R5 above top");

        // R1 reset mid-run, strategy taken from select during reset
        do_reset(2'd2);
        sweep(30, 3, "R9 R1 reset sel");

        drive(0, 1'b0, 1'b0, "idle");
        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb.size(), 0);
        finish_run();
    end

endmodule